// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting interval timer for generating a regular system heartbeat. Firmware programs a period register with the desired period minus one, clears the live count, then turns counting on through a control register. Each tick moves a 24-bit count one step toward zero. A tick is either every core clock or, through a divide-by-eight enable, once per eight core clocks.

The count passes from one to zero on a tick. When that happens, the timer latches a sticky wrap flag and, if enabled, pulses an interrupt request for one core clock. On the tick after that it refills from the period register. All three registers sit on a simple single-cycle register bus. Reads are combinational from the addressed register. Writes take effect on the clock edge.

Top module: `tick_timer`

## Requirements
- R1: With the source bit (control bit 2) at 1 and counting on, the live count changes on every core clock edge.
- R2: With the source bit at 0, the count changes only on every eighth core clock edge while counting is on. The divide-by-eight phase returns to its start on any write to the current-value register, so the first tick comes on the eighth edge after counting is switched on.
- R3: When a tick finds the count at zero, the count loads the period register. A period value of N-1 therefore gives one wrap every N ticks.
- R4: The period register (byte offset 0x4) keeps bits 23:0 of the written word, ignores bits 31:24, and reads back with those bits zero.
- R5: Any write to the current-value register (byte offset 0x8) sets the count to zero, whatever the data. It also clears the wrap flag.
- R6: Control bit 0 starts and stops counting. While it is 0, the count holds its value.
- R7: A tick that takes the count from 1 to 0 sets the wrap flag (control bit 16). A read of the control register (byte offset 0x0) returns the flag and then clears it. If that read falls in the same cycle as a new wrap, the read returns the old value and the flag stays set.
- R8: When control bit 1 is 1, each wrap raises `irq` for exactly one core clock, in the cycle after the edge where the count reached zero. When control bit 1 is 0, `irq` stays low.
- R9: While the period register is zero, a 1-to-0 step neither sets the flag nor raises `irq`, and the count then stays at zero.
- R10: Reserved control bits read as zero. Unmapped offset 0xC reads zero. The current-value register reads the live count in bits 23:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A control-register read can land on the same edge where the count steps from one to zero. The read then wants to clear the wrap flag while the wrap wants to set it. The bench starts the core-clock mode with a period of five and counts cycles from the enabling write. It aims a control read exactly at the wrap edge. It judges the outcome with two checks: that read must show the flag clear, and the very next read must show it set. The scoreboard also expects the interrupt pulse in the cycle that follows.

// File: rtl/tick_pkg.sv
// Package: shared constants for the tick timer.
// Holds control-register bit positions and the register select encoding.
// Assumes a 32-bit register bus with word-aligned byte offsets.
package tick_pkg;
    localparam int CTRL_RUN  = 0;   // counting enable
    localparam int CTRL_TIE  = 1;   // interrupt enable
    localparam int CTRL_SRC  = 2;   // 1 = core clock, 0 = divided
    localparam int CTRL_FLAG = 16;  // sticky wrap flag

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_LIVE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Produces the counting enable. With the core source, it is high on every
// cycle while running. Otherwise it is high once per DIV cycles while running.
// The phase counter advances only while running on the divided source.
// A restart pulse returns the phase to zero. Assumes DIV >= 2.
module tick_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic src_core,
    input  logic restart,
    output logic tick
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase;

    // Advance the divide phase; wrap at DIV-1; restart forces zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (run && !src_core) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    // Issue a tick: every cycle on the core source, else at the last phase.
    always_comb begin
        tick = run && (src_core || (phase == PH_LAST));
    end

    // A divided tick is never followed at once by another divided tick.
    p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !src_core && !restart) |=> (!tick || src_core));

    // Restart returns the divider to its first phase.
    p_phase_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
endmodule

// File: rtl/tick_downcounter.sv
// Module: tick_downcounter
// The live count register. On a tick at zero it refills from the period
// value. On any other tick it steps down by one. A clear forces zero and
// wins over a tick. It signals a wrap on a 1-to-0 step while the period
// is nonzero.
module tick_downcounter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Update the count: clear, refill at zero, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            if (count == '0) begin
                count <= period;
            end else begin
                count <= count - ONE;
            end
        end
    end

    // Detect the wrap event that feeds the flag and the interrupt.
    always_comb begin
        wrap = tick && !clear && (count == ONE) && (period != '0);
    end

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    p_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && count == '0) |=> (count == $past(period)));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && count != '0) |=> (count == $past(count) - ONE));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(count));
endmodule

// File: rtl/tick_regs.sv
// Module: tick_regs
// Register file and bus decode. It holds the control bits, the masked period
// value, the sticky wrap flag and the registered interrupt pulse. Reads are
// combinational in the strobe cycle. A control read clears the flag on the
// same edge, but a wrap on that edge wins. Assumes single-cycle accesses.
module tick_regs
    import tick_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic [CNT_W-1:0]  period,
    output logic              run,
    output logic              src_core,
    output logic              live_wr,
    output logic              irq
);
    reg_sel_e sel;
    logic     ctrl_wr, ctrl_rd, period_wr;
    logic     tie, flag;
    logic     unused_bits;

    // Decode the word select and the access kind.
    always_comb begin
        sel       = reg_sel_e'(bus_addr[3:2]);
        ctrl_wr   = bus_sel &&  bus_wr && (sel == SEL_CTRL);
        ctrl_rd   = bus_sel && !bus_wr && (sel == SEL_CTRL);
        period_wr = bus_sel &&  bus_wr && (sel == SEL_PERIOD);
        live_wr   = bus_sel &&  bus_wr && (sel == SEL_LIVE);
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CNT_W]};

    // Hold the control bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            tie      <= 1'b0;
            src_core <= 1'b0;
        end else if (ctrl_wr) begin
            run      <= bus_wdata[CTRL_RUN];
            tie      <= bus_wdata[CTRL_TIE];
            src_core <= bus_wdata[CTRL_SRC];
        end
    end

    // Hold the period value, keeping only the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (period_wr) begin
            period <= bus_wdata[CNT_W-1:0];
        end
    end

    // Sticky wrap flag: set by a wrap, cleared by a control read or a live write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (ctrl_rd || live_wr) begin
            flag <= 1'b0;
        end
    end

    // One-cycle interrupt pulse following an enabled wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap && tie;
        end
    end

    // Return the addressed register; reserved and unmapped bits read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    bus_rdata[CTRL_RUN]  = run;
                    bus_rdata[CTRL_TIE]  = tie;
                    bus_rdata[CTRL_SRC]  = src_core;
                    bus_rdata[CTRL_FLAG] = flag;
                end
                SEL_PERIOD: bus_rdata = DATA_W'(period);
                SEL_LIVE:   bus_rdata = DATA_W'(count);
                SEL_NONE:   bus_rdata = '0;
            endcase
        end
    end

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !wrap) |=> !flag);

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && tie) |=> irq);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_period_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> (period == $past(bus_wdata[CNT_W-1:0])));

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (bus_rdata[DATA_W-1:CTRL_FLAG+1] == '0 &&
                     bus_rdata[CTRL_FLAG-1:CTRL_SRC+1] == '0));
endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer (top)
// Joins the register file, the divide-by-DIV tick enable and the live
// down-counter. A write to the live register both zeroes the count and
// restarts the divider phase. Assumes a byte-addressed bus with ADDR_W >= 4.
module tick_timer #(
    parameter int CNT_W  = 24,
    parameter int DIV    = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] count, period;
    logic             run, src_core, live_wr, tick, wrap;

    tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .wrap(wrap), .period(period), .run(run),
        .src_core(src_core), .live_wr(live_wr), .irq(irq)
    );

    tick_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .src_core(src_core),
        .restart(live_wr), .tick(tick)
    );

    tick_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(live_wr),
        .period(period), .count(count), .wrap(wrap)
    );

    p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !live_wr) |=> $stable(count));

    p_zero_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && count == '0) |=> (count == '0 && !irq));
endmodule

// File: tb/tick_timer_test.sv
// Scoreboard bench: driver tasks push the expected interrupt cycles into a
// queue; a monitor at each falling edge pops and compares them.
module tick_timer_test;
    localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_LIVE = 4'h8, A_NONE = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit armed = 1'b0;
    bit done = 1'b0;
    int exp_q[$];

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare each interrupt pulse against the queue head (R8).
    always @(negedge clk) begin
        if (armed) begin
            if (irq) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front());
                    check(1'b1, "R8", 32'(cyc), 32'(cyc));
                end else begin
                    check(1'b0, "R8 unexpected irq", 32'(cyc),
                          (exp_q.size() > 0) ? 32'(exp_q[0]) : 32'hFFFF_FFFF);
                end
            end else if (exp_q.size() > 0 && exp_q[0] <= cyc) begin
                check(1'b0, "R8 missed irq", 32'(cyc), 32'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push_irqs(input int first, input int step, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(first + k * step);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 32'(cyc), 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        check(irq == 1'b0, "R8 reset irq", 32'(irq), 32'd0);
        rd_expect(A_CTRL, 32'h0, "R10 reset ctrl");
        rd_expect(A_PER, 32'h0, "R4 reset period");
        rd_expect(A_LIVE, 32'h0, "R10 reset live");

        // R4: upper period bits are dropped.
        wr(A_PER, 32'hFF00_0004);
        rd_expect(A_PER, 32'h0000_0004, "R4 mask");
        // R10: reserved control bits read zero; unmapped offset reads zero.
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_expect(A_CTRL, 32'h0000_0007, "R10 reserved");
        wr(A_CTRL, 32'h0);
        rd_expect(A_NONE, 32'h0, "R10 unmapped");

        // R1/R3/R8: core source, period 5 -> irq at E+5, E+10, E+15.
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h7);
        e = cyc;
        push_irqs(e + 5, 5, 3);
        wait_to(e + 2);
        rd_expect(A_LIVE, 32'd3, "R1 live count");
        wait_to(e + 16);
        wr(A_CTRL, 32'h0);            // stops at edge E+17, count 4->3
        rd_expect(A_CTRL, 32'h0001_0000, "R7 flag set");
        rd_expect(A_CTRL, 32'h0, "R7 flag cleared by read");
        repeat (5) @(negedge clk);
        rd_expect(A_LIVE, 32'd3, "R6 hold while stopped");

        // R7: control read on the wrap edge E+5.
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h7);
        e = cyc;
        push_irqs(e + 5, 5, 1);
        wait_to(e + 4);
        rd_expect(A_CTRL, 32'h0000_0007, "R7 same-cycle read sees old");
        rd_expect(A_CTRL, 32'h0001_0007, "R7 set wins over clear");
        rd_expect(A_CTRL, 32'h0000_0007, "R7 cleared after");
        wr(A_CTRL, 32'h0);

        // R8: interrupt disabled -> flag only.
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h5);
        e = cyc;
        wait_to(e + 6);
        rd_expect(A_CTRL, 32'h0001_0005, "R8 flag without irq");
        wr(A_CTRL, 32'h0);

        // R2: divided source, period 3 -> ticks at E+8k, irq at E+24, E+48.
        wr(A_PER, 32'd2);
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h3);
        e = cyc;
        push_irqs(e + 24, 24, 2);
        wait_to(e + 7);
        rd_expect(A_LIVE, 32'd0, "R2 no tick before eighth edge");
        rd_expect(A_LIVE, 32'd2, "R2 first tick on eighth edge");
        wait_to(e + 50);
        wr(A_CTRL, 32'h0);            // divider phase left mid-way
        // R2/R5: live write restarts the divider phase.
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h3);
        e = cyc;
        push_irqs(e + 24, 24, 1);
        wait_to(e + 26);
        wr(A_CTRL, 32'h0);

        // R5: live write clears count and flag.
        wr(A_PER, 32'd3);
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h5);
        e = cyc;
        wait_to(e + 9);
        wr(A_CTRL, 32'h0);            // edge E+10, count 3->2
        rd_expect(A_LIVE, 32'd2, "R6 stop value");
        wr(A_LIVE, 32'h005A_5A5A);
        rd_expect(A_LIVE, 32'd0, "R5 live cleared");
        rd_expect(A_CTRL, 32'h0, "R5 flag cleared");

        // R9: zero period suppresses the wrap and parks at zero.
        wr(A_LIVE, 32'h0);
        wr(A_CTRL, 32'h7);
        e = cyc;
        push_irqs(e + 4, 4, 1);
        wait_to(e + 5);
        rd_expect(A_CTRL, 32'h0001_0007, "R9 prior wrap");
        wr(A_PER, 32'h0);             // edge E+7, count 2->1
        wait_to(e + 20);
        rd_expect(A_CTRL, 32'h0000_0007, "R9 no flag");
        rd_expect(A_LIVE, 32'd0, "R9 parked at zero");
        wr(A_CTRL, 32'h0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all pulses seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule